// File: doc/BRIEF.md
# Two-Wire Sample Register Slave with Skip-Low-Byte Bursts

This block is a two-wire (I2C) bus target that exposes a tiny register space to a host controller. A sensing front end hands it three 12-bit axis samples at once on a parallel input qualified by a one-cycle valid strobe. The host reads those samples over the bus together with a status byte that reports, for each axis, whether data is fresh and whether a sample was lost to a newer one. A configuration register selects which axes are live and turns on a fast burst mode that walks only the high bytes. A scratch register is free for host use.

The bus lines are oversampled by the system clock. START, repeated START and STOP are found on the synchronised lines. The target answers a 7-bit address whose low bit comes from a strap input. The first data byte of a write loads the register pointer. Later bytes are stored at the pointer, which advances after each byte. A read is a pointer write, a repeated START and a read-addressed phase that streams bytes while the host acknowledges. SDA is open-drain: the block only ever pulls it low, through an output-enable.

Top module: `i2c_sample_slave`

## Requirements
- R1: The block acknowledges address 0x1C when `addr_strap` is 0 and 0x1D when it is 1. Any other address gets no acknowledge and leaves the block idle until the next START.
- R2: A falling SDA while SCL is high is a START, and a START inside a transfer is a repeated START. A rising SDA while SCL is high is a STOP, which ends the transfer and releases SDA.
- R3: The block changes `sda_oe` only while SCL is low. It asserts `sda_oe` during the ninth clock of every byte it acknowledges.
- R4: In a write, the first byte after the address loads the pointer. Each later byte is written at the pointer, the pointer then advances, and every byte is acknowledged.
- R5: After a repeated START with the read bit set, the block sends the byte at the pointer and advances the pointer. It keeps sending while the host acknowledges, and stops driving after a not-acknowledge.
- R6: Axis registers: X high byte at 0x01, X low at 0x02, Y high at 0x03, Y low at 0x04, Z high at 0x05, Z low at 0x06. A high byte holds sample bits [11:4]. A low byte holds sample bits [3:0] in [7:4] and zeros in [3:0].
- R7: With fast mode off, the pointer steps 0x00 to 0x06 one by one, and the step after 0x06 goes to 0x00. With fast mode on, it steps 0x01 to 0x03 to 0x05, and the step after 0x05 goes to 0x00.
- R8: Status at 0x00 holds, from bit 7 down: any-overwrite, Z overwrite, Y overwrite, X overwrite, any-new, Z new, Y new, X new. A valid strobe sets the new bit of each enabled axis and the any-new bit. An axis new bit clears when that axis' high byte is read. Any-new clears once the high bytes of all enabled axes have been read.
- R9: If a valid strobe arrives while an enabled axis' new bit is still set, that axis' overwrite bit and any-overwrite are set. All overwrite bits clear only when the high bytes of all enabled axes have been read.
- R10: Writes to 0x00 through 0x06 are acknowledged and have no effect.
- R11: Config at 0x07 holds fast mode in bit 0 and the X, Y, Z enables in bits 1, 2, 3, and resets to 0x0E. A disabled axis keeps its sample registers and flags unchanged, and its high byte is not needed to clear the any-flags.
- R12: After reset the status byte, all sample bytes and the scratch register at 0x08 read 0x00, the config register reads 0x0E, and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_strap | input | 1 | Sets the low bit of the bus address |
| smp_vld | input | 1 | One-cycle strobe for a new sample set |
| smp_x | input | SAMPLE_W | X-axis sample |
| smp_y | input | SAMPLE_W | Y-axis sample |
| smp_z | input | SAMPLE_W | Z-axis sample |

## Verification
The bench drives the pointer past the last output register in both burst modes. A design that wraps at the wrong place would return a low byte or a configuration byte where the status byte should be. It pushes two sample sets without reading in between and then reads the high bytes one at a time. An overwrite flag that clears on its own axis' read, instead of waiting for all enabled axes, shows up as a wrong status byte in the middle of that sequence. It also disables one axis, writes to read-only addresses and moves the address strap. These catch a dead axis that still updates or still blocks the clear, a read-only byte that can be changed, and an address decode that ignores the strap.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int AXES = 3;

  localparam logic [7:0] RA_STAT = 8'h00;
  localparam logic [7:0] RA_LAST = 8'h06;
  localparam logic [7:0] RA_CFG  = 8'h07;
  localparam logic [7:0] RA_SCR  = 8'h08;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_RX,
    BS_ACK,
    BS_TX,
    BS_MACK
  } bus_st_t;

  // High-byte register address of axis a (0 = X)
  function automatic logic [7:0] hi_reg(input int a);
    return 8'(1 + 2 * a);
  endfunction

  // Pointer step after each byte transferred
  function automatic logic [7:0] ptr_step(input logic [7:0] p, input logic fast);
    logic [7:0] n;
    if (fast && (p == 8'h01 || p == 8'h03)) n = p + 8'd2;
    else if (fast && p == 8'h05)            n = RA_STAT;
    else if (p == RA_LAST)                  n = RA_STAT;
    else                                    n = p + 8'd1;
    return n;
  endfunction

  // Bus address from a base and the strap level
  function automatic logic [6:0] bus_addr(input logic [6:0] base, input logic strap);
    return {base[6:1], strap};
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [6:0] dev_addr,
  input  logic       fast_rd,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] reg_ptr,
  output logic       rd_stb,
  output logic       wr_stb,
  output logic [7:0] wr_data
);

  bus_st_t    st;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       in_addr, is_read, ptr_pend, host_nak;
  logic       byte_done, bus_evt;

  assign bus_evt   = start_evt | stop_evt;
  assign byte_done = (st == BS_RX) && scl_fall && (bit_cnt == 4'd8) && !bus_evt;
  assign wr_stb    = byte_done && !in_addr && !ptr_pend;
  assign wr_data   = shreg;
  assign rd_stb    = !bus_evt && scl_fall &&
                     (((st == BS_ACK) && is_read) || ((st == BS_MACK) && !host_nak));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= BS_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      in_addr  <= 1'b0;
      is_read  <= 1'b0;
      ptr_pend <= 1'b0;
      host_nak <= 1'b0;
      sda_oe   <= 1'b0;
      reg_ptr  <= '0;
    end else if (start_evt) begin
      st      <= BS_RX;
      bit_cnt <= '0;
      in_addr <= 1'b1;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      st     <= BS_IDLE;
      sda_oe <= 1'b0;
    end else if (rd_stb) begin
      // load the next byte to send and drive its first bit
      st      <= BS_TX;
      shreg   <= rd_data;
      sda_oe  <= ~rd_data[7];
      bit_cnt <= 4'd1;
      reg_ptr <= ptr_step(reg_ptr, fast_rd);
    end else begin
      unique case (st)
        BS_IDLE: ;
        BS_RX: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            in_addr <= 1'b0;
            if (in_addr) begin
              if (shreg[7:1] == dev_addr) begin
                st       <= BS_ACK;
                sda_oe   <= 1'b1;
                is_read  <= shreg[0];
                ptr_pend <= ~shreg[0];
              end else begin
                st <= BS_IDLE;
              end
            end else begin
              st     <= BS_ACK;
              sda_oe <= 1'b1;
              if (ptr_pend) begin
                reg_ptr  <= shreg;
                ptr_pend <= 1'b0;
              end else begin
                reg_ptr <= ptr_step(reg_ptr, fast_rd);
              end
            end
          end
        end
        BS_ACK: begin
          if (scl_fall) begin
            st      <= BS_RX;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
          end
        end
        BS_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              st     <= BS_MACK;
              sda_oe <= 1'b0;
            end else begin
              sda_oe  <= ~shreg[6];
              shreg   <= {shreg[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        BS_MACK: begin
          if (scl_rise) host_nak <= sda_s;
          else if (scl_fall) st <= BS_IDLE;
        end
        default: st <= BS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
  import i2cs_pkg::*;
#(
  parameter int         SAMPLE_W  = 12,
  parameter logic [7:0] CFG_RESET = 8'h0E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_x,
  input  logic [SAMPLE_W-1:0] smp_y,
  input  logic [SAMPLE_W-1:0] smp_z,
  input  logic [7:0]          reg_ptr,
  input  logic                rd_stb,
  input  logic                wr_stb,
  input  logic [7:0]          wr_data,
  output logic [7:0]          rd_data,
  output logic                fast_rd,
  output logic [AXES-1:0]     axis_en,
  output logic [AXES-1:0]     dr_axis,
  output logic [AXES-1:0]     ow_axis,
  output logic                dr_all,
  output logic                ow_all,
  output logic                all_read
);

  localparam int LO_W = SAMPLE_W - 8;
  localparam int PAD  = 8 - LO_W;

  logic [SAMPLE_W-1:0]   smp_in [AXES];
  logic [AXES-1:0][7:0]  hi_b, lo_b;
  logic [AXES-1:0]       msb_hit, seen, new_s;
  logic [AXES-1:0]       seen_next;
  logic [7:0]            cfg_q, scr_q;

  assign smp_in[0] = smp_x;
  assign smp_in[1] = smp_y;
  assign smp_in[2] = smp_z;

  assign fast_rd = cfg_q[0];
  assign axis_en = cfg_q[3:1];

  assign seen_next = seen | msb_hit;
  assign all_read  = (|msb_hit) && (|axis_en) && ((seen_next & axis_en) == axis_en);

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    localparam logic [7:0] HI = hi_reg(a);
    logic [SAMPLE_W-1:0] q;
    logic d, o, s;

    assign msb_hit[a] = rd_stb && (reg_ptr == HI);
    assign new_s[a]   = smp_vld && axis_en[a];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        d <= 1'b0;
        o <= 1'b0;
        s <= 1'b0;
      end else begin
        if (new_s[a]) q <= smp_in[a];
        if (new_s[a])        d <= 1'b1;
        else if (msb_hit[a]) d <= 1'b0;
        if (new_s[a] && d)   o <= 1'b1;
        else if (all_read)   o <= 1'b0;
        if (new_s[a] || all_read) s <= 1'b0;
        else if (msb_hit[a])      s <= 1'b1;
      end
    end

    assign dr_axis[a] = d;
    assign ow_axis[a] = o;
    assign seen[a]    = s;
    assign hi_b[a]    = q[SAMPLE_W-1 -: 8];
    assign lo_b[a]    = {q[LO_W-1:0], {PAD{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_all <= 1'b0;
      ow_all <= 1'b0;
      cfg_q  <= CFG_RESET;
      scr_q  <= '0;
    end else begin
      if (|new_s)        dr_all <= 1'b1;
      else if (all_read) dr_all <= 1'b0;
      if (|(new_s & dr_axis)) ow_all <= 1'b1;
      else if (all_read)      ow_all <= 1'b0;
      if (wr_stb && reg_ptr == RA_CFG) cfg_q <= wr_data;
      if (wr_stb && reg_ptr == RA_SCR) scr_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (reg_ptr == RA_STAT) rd_data = {ow_all, ow_axis[2], ow_axis[1], ow_axis[0],
                                       dr_all, dr_axis[2], dr_axis[1], dr_axis[0]};
    if (reg_ptr == RA_CFG)  rd_data = cfg_q;
    if (reg_ptr == RA_SCR)  rd_data = scr_q;
    for (int a = 0; a < AXES; a++) begin
      if (reg_ptr == hi_reg(a))         rd_data = hi_b[a];
      if (reg_ptr == hi_reg(a) + 8'd1)  rd_data = lo_b[a];
    end
  end

endmodule

// File: rtl/i2c_sample_slave.sv
module i2c_sample_slave
  import i2cs_pkg::*;
#(
  parameter int         SAMPLE_W    = 12,
  parameter logic [6:0] BASE_ADDR   = 7'h1C,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CFG_RESET   = 8'h0E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic                addr_strap,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_x,
  input  logic [SAMPLE_W-1:0] smp_y,
  input  logic [SAMPLE_W-1:0] smp_z
);

  logic            scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0]      reg_ptr, rd_data, wr_data;
  logic            rd_stb, wr_stb, fast_rd;
  logic [AXES-1:0] axis_en, dr_axis, ow_axis;
  logic            dr_all, ow_all, all_read;
  logic [6:0]      dev_addr;

  assign dev_addr = bus_addr(BASE_ADDR, addr_strap);

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_proto u_proto (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_addr(dev_addr), .fast_rd(fast_rd), .rd_data(rd_data),
    .sda_oe(sda_oe), .reg_ptr(reg_ptr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  i2cs_regfile #(.SAMPLE_W(SAMPLE_W), .CFG_RESET(CFG_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .reg_ptr(reg_ptr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .fast_rd(fast_rd), .axis_en(axis_en),
    .dr_axis(dr_axis), .ow_axis(ow_axis), .dr_all(dr_all), .ow_all(ow_all),
    .all_read(all_read)
  );

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
  import i2cs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            smp_vld,
  input logic            scl_s,
  input logic            sda_oe,
  input logic            stop_evt,
  input logic            rd_stb,
  input logic [7:0]      reg_ptr,
  input logic            fast_rd,
  input logic [AXES-1:0] axis_en,
  input logic [AXES-1:0] dr_axis,
  input logic [AXES-1:0] ow_axis,
  input logic            ow_all,
  input logic            all_read
);

  a_r3_oe_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r3_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  a_r7_fast_skip_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && fast_rd && reg_ptr == 8'h01) |=> (reg_ptr == 8'h03));

  a_r7_wrap_to_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !fast_rd && reg_ptr == 8'h06) |=> (reg_ptr == 8'h00));

  a_r9_axis_ow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && axis_en[0] && dr_axis[0]) |=> ow_axis[0]);

  a_r9_ow_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ow_all) |-> $past(rd_stb));

  a_r9_all_read_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    all_read |-> rd_stb);

endmodule

bind i2c_sample_slave i2cs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .scl_s(scl_s), .sda_oe(sda_oe),
  .stop_evt(stop_evt), .rd_stb(rd_stb), .reg_ptr(reg_ptr), .fast_rd(fast_rd),
  .axis_en(axis_en), .dr_axis(dr_axis), .ow_axis(ow_axis), .ow_all(ow_all),
  .all_read(all_read)
);

// File: tb/tb_i2c_sample_slave.sv
`timescale 1ns/1ps
module tb_i2c_sample_slave;

  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl, m_sda, sda_oe, strap, vld;
  logic [11:0] sx, sy, sz;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  i2c_sample_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(strap), .smp_vld(vld), .smp_x(sx), .smp_y(sy), .smp_z(sz)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] rbuf [0:7];
  logic [7:0] wbuf [0:7];

  // {x, y, z} sample sets
  localparam logic [35:0] VEC [0:3] = '{
    36'h000_FFF_800, 36'h7FF_801_001, 36'hA5C_3E1_0F0, 36'h123_456_789
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic drv, output logic smp);
    q(); m_sda = drv; q(); m_scl = 1'b1; q(); smp = sda_line; q(); m_scl = 1'b0;
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0;
  endtask

  task automatic i2c_rstart();
    q(); m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0;
  endtask

  task automatic i2c_stop();
    q(); m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], d);
    bit_xfer(1'b1, d);
    ack = ~d;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic v;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(1'b1, v);
      b = {b[6:0], v};
    end
    bit_xfer(~give_ack, v);
  endtask

  function automatic logic [6:0] dev();
    return {6'b001110, strap};
  endfunction

  task automatic wr_regs(input logic [7:0] p, input int n, output int naks);
    logic a;
    naks = 0;
    i2c_start();
    send_byte({dev(), 1'b0}, a); naks += int'(!a);
    send_byte(p, a);             naks += int'(!a);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); naks += int'(!a);
    end
    i2c_stop();
  endtask

  task automatic rd_regs(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] b;
    int naks = 0;
    i2c_start();
    send_byte({dev(), 1'b0}, a); naks += int'(!a);
    send_byte(p, a);             naks += int'(!a);
    i2c_rstart();
    send_byte({dev(), 1'b1}, a); naks += int'(!a);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      rbuf[k] = b;
    end
    i2c_stop();
    chk("R5 read phase acks", 8'(naks), 8'h00);
    chk("R2 bus released after stop", {7'h0, sda_oe}, 8'h00);
  endtask

  task automatic push(input logic [35:0] s);
    @(negedge clk);
    {sx, sy, sz} = s;
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    q();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int naks;
    logic a;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 1'b0; vld = 1'b0;
    sx = '0; sy = '0; sz = '0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    q();

    // R12 reset state
    chk("R12 sda_oe after reset", {7'h0, sda_oe}, 8'h00);
    rd_regs(8'h00, 7);
    for (int k = 0; k < 7; k++) chk("R12 status and sample bytes at reset", rbuf[k], 8'h00);
    rd_regs(8'h07, 2);
    chk("R12 config reset", rbuf[0], 8'h0E);
    chk("R12 scratch reset", rbuf[1], 8'h00);

    // R5 R6 R7 R8: table of sample sets, full burst from status
    for (int v = 0; v < 4; v++) begin
      logic [11:0] ex, ey, ez;
      {ex, ey, ez} = VEC[v];
      push(VEC[v]);
      rd_regs(8'h00, 7);
      chk("R8 status after fresh sample", rbuf[0], 8'h0F);
      chk("R6 X high", rbuf[1], ex[11:4]);
      chk("R6 X low",  rbuf[2], {ex[3:0], 4'h0});
      chk("R6 Y high", rbuf[3], ey[11:4]);
      chk("R6 Y low",  rbuf[4], {ey[3:0], 4'h0});
      chk("R7 Z high", rbuf[5], ez[11:4]);
      chk("R7 Z low",  rbuf[6], {ez[3:0], 4'h0});
      rd_regs(8'h00, 1);
      chk("R8 status cleared after high bytes", rbuf[0], 8'h00);
    end

    // R7 wrap with fast mode off: 0x06 then 0x00
    rd_regs(8'h06, 2);
    chk("R7 wrap slow low byte", rbuf[0], 8'h90);
    chk("R7 wrap slow to status", rbuf[1], 8'h00);

    // R11 R7 fast mode
    wbuf[0] = 8'h0F;
    wr_regs(8'h07, 1, naks);
    chk("R4 config write acks", 8'(naks), 8'h00);
    push(36'hABC_DEF_135);
    rd_regs(8'h00, 4);
    chk("R7 fast status", rbuf[0], 8'h0F);
    chk("R7 fast X high", rbuf[1], 8'hAB);
    chk("R7 fast Y high", rbuf[2], 8'hDE);
    chk("R7 fast Z high", rbuf[3], 8'h13);
    rd_regs(8'h00, 1);
    chk("R8 fast burst clears status", rbuf[0], 8'h00);
    rd_regs(8'h05, 2);
    chk("R7 fast wrap Z high", rbuf[0], 8'h13);
    chk("R7 fast wrap to status", rbuf[1], 8'h00);

    // R9 overwrite, slow mode
    wbuf[0] = 8'h0E;
    wr_regs(8'h07, 1, naks);
    push(36'h111_222_333);
    push(36'h444_555_666);
    rd_regs(8'h00, 1);
    chk("R9 overwrite all set", rbuf[0], 8'hFF);
    rd_regs(8'h01, 1);
    chk("R9 latest X high kept", rbuf[0], 8'h44);
    rd_regs(8'h00, 1);
    chk("R9 overwrite held after one axis read", rbuf[0], 8'hFE);
    rd_regs(8'h03, 1);
    chk("R9 Y high", rbuf[0], 8'h55);
    rd_regs(8'h00, 1);
    chk("R9 overwrite held after two axes", rbuf[0], 8'hFC);
    rd_regs(8'h05, 1);
    chk("R9 Z high", rbuf[0], 8'h66);
    rd_regs(8'h00, 1);
    chk("R9 overwrite cleared after all axes", rbuf[0], 8'h00);

    // R10 writes to read-only registers
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5; wbuf[2] = 8'h3C;
    wr_regs(8'h00, 3, naks);
    chk("R10 read-only writes acked", 8'(naks), 8'h00);
    rd_regs(8'h00, 3);
    chk("R10 status unchanged", rbuf[0], 8'h00);
    chk("R10 X high unchanged", rbuf[1], 8'h44);
    chk("R10 X low unchanged", rbuf[2], 8'h40);

    // R4 multi-byte write with auto-increment
    wbuf[0] = 8'h0E; wbuf[1] = 8'hA5;
    wr_regs(8'h07, 2, naks);
    chk("R4 burst write acks", 8'(naks), 8'h00);
    rd_regs(8'h07, 2);
    chk("R4 config after burst write", rbuf[0], 8'h0E);
    chk("R4 scratch after burst write", rbuf[1], 8'hA5);

    // R11 disabled Y axis
    wbuf[0] = 8'h0A;
    wr_regs(8'h07, 1, naks);
    push(36'h999_888_777);
    rd_regs(8'h00, 7);
    chk("R11 status with Y off", rbuf[0], 8'h0D);
    chk("R11 X high", rbuf[1], 8'h99);
    chk("R11 X low", rbuf[2], 8'h90);
    chk("R11 Y high frozen", rbuf[3], 8'h55);
    chk("R11 Y low frozen", rbuf[4], 8'h50);
    chk("R11 Z high", rbuf[5], 8'h77);
    chk("R11 Z low", rbuf[6], 8'h70);
    rd_regs(8'h00, 1);
    chk("R11 clear without Y", rbuf[0], 8'h00);

    // R1 address decode with strap
    i2c_start();
    send_byte({7'h1D, 1'b0}, a);
    i2c_stop();
    chk("R1 wrong address not acked", {7'h0, a}, 8'h00);
    strap = 1'b1;
    q();
    i2c_start();
    send_byte({7'h1C, 1'b0}, a);
    i2c_stop();
    chk("R1 old address rejected after strap", {7'h0, a}, 8'h00);
    wbuf[0] = 8'h3C;
    wr_regs(8'h08, 1, naks);
    chk("R1 strap high address acked", 8'(naks), 8'h00);
    rd_regs(8'h08, 1);
    chk("R1 scratch via strap address", rbuf[0], 8'h3C);
    strap = 1'b0;
    q();

    summary();
    $finish;
  end

endmodule